// File: doc/BRIEF.md
# Recursive Single-Element 5/3 Row Lifting Transform

This block performs the horizontal (one-dimensional) step of a reversible 5/3 lifting wavelet transform. It takes one pixel per clock. Every pixel enters an eight-slot shift bank that advances on every clock edge. One arithmetic element serves both lifting steps by time-sharing. When an odd sample reaches the first slot, the element runs a predict step, and its high-pass result replaces that odd sample in slot 3. When a high-pass value reaches slot 4, the element runs an update step, and its low-pass result replaces the matching even sample in slot 7. High-pass coefficients leave from slot 4 and low-pass coefficients from slot 8. Both share a single output port that carries a tag.

Rows have a fixed length, set by the parameter `ROW_LEN`, which must be even. Each row is transformed on its own, with zero extension at both ends. The block has no flow control. Coefficients appear a fixed number of clocks after the samples that produce them.

Top module: `lift_row_top`

## Requirements
- R1: While reset is applied, and after it until the first coefficient of the first row is due, `out_valid` stays low.
- R2: The high-pass value is H[i] = x[2i+1] - floor((x[2i] + x[2i+2]) / 2). The value x[ROW_LEN] is taken as 0, so the last H of a row ignores whatever the input port carries next.
- R3: The low-pass value is L[i] = x[2i] + floor((H[i-1] + H[i] + 2) / 4). The value H[-1] is taken as 0 for the first L of each row.
- R4: Take e as the clock edge that captures x[0]. H[i] is on the output after edge e+2i+4, and L[i] after edge e+2i+7. Each is visible for exactly one cycle.
- R5: `out_high` is 1 for a high-pass coefficient and 0 for a low-pass one. Each row yields ROW_LEN/2 of each. Two coefficients with the same tag are never valid on consecutive cycles.
- R6: The shared element starts at most one operation per clock, and predict and update alternate on consecutive clocks within a row. A predict result always lands in the slot that holds its odd sample, and an update result in the slot that holds its even sample.
- R7: A sample with `in_valid` low has no effect. A sample with `in_valid` high that arrives outside a row (no start and no active row) also has no effect. Neither kind produces an output or changes any coefficient.
- R8: A row is ROW_LEN contiguous valid samples, the first flagged by `row_start`. The next row may follow back-to-back or after an even number of idle cycles. Every row is transformed independently of its neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample present this cycle |
| row_start | input | 1 | Marks sample 0 of a row (used with in_valid) |
| in_sample | input | DATA_W | Unsigned pixel |
| out_valid | output | 1 | Coefficient present this cycle |
| out_high | output | 1 | 1 = high-pass, 0 = low-pass |
| out_coef | output | DATA_W+2 | Signed coefficient |

## Verification
Counting from the edge that captures a row's first sample, H[i] is due after exactly 2i+4 edges and L[i] after 2i+7 edges. The bench records that edge number when it drives the first sample. It writes each reference coefficient into a slot of a cycle-indexed schedule. It then compares the outputs against that slot half a clock after every edge. Any valid, tag or value that arrives one cycle early or late fails, and so does any output in a cycle where nothing is scheduled.

// File: rtl/lift_pkg.sv
package lift_pkg;
  // bank geometry: positions follow from the two-stage element timing
  localparam int BANK_DEPTH = 8;
  localparam int PRED_SLOT  = 3;  // predict result replaces its odd sample here
  localparam int UPD_SLOT   = 7;  // update result replaces its even sample here
  localparam int HI_TAP     = 4;  // high-pass leaves from this slot
  localparam int LO_TAP     = 8;  // low-pass leaves from this slot

  typedef enum logic {
    OP_PREDICT = 1'b0,
    OP_UPDATE  = 1'b1
  } lift_op_e;

  typedef struct packed {
    logic vld;
    logic odd;
    logic first;
    logic last;
  } slot_meta_t;
endpackage

// File: rtl/lift_rst_sync.sv
module lift_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      rst_n_o <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n_o <= stage_q;
    end
  end
endmodule

// File: rtl/lift_ctrl.sv
module lift_ctrl import lift_pkg::*; #(
  parameter int ROW_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       row_start,
  output slot_meta_t meta_o
);
  localparam int CW = (ROW_LEN > 2) ? $clog2(ROW_LEN) : 1;

  logic          active_q, active_d;
  logic [CW-1:0] col_q, col_d;
  logic          idle_odd_q, idle_odd_d;
  logic          seen_q, seen_d;
  logic          start, take, at_end;
  logic [CW-1:0] idx;

  always_comb begin
    start  = in_valid & row_start;
    take   = start | (in_valid & active_q);
    idx    = start ? '0 : col_q;
    at_end = take && (idx == CW'(ROW_LEN - 1));

    meta_o.vld   = take;
    meta_o.odd   = idx[0];
    meta_o.first = start;
    meta_o.last  = at_end;

    col_d      = col_q;
    active_d   = active_q;
    idle_odd_d = idle_odd_q;
    seen_d     = seen_q | at_end;
    if (take) begin
      col_d      = at_end ? '0 : idx + 1'b1;
      active_d   = !at_end;
      idle_odd_d = 1'b0;
    end else if (!active_q) begin
      idle_odd_d = ~idle_odd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      col_q      <= '0;
      idle_odd_q <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      active_q   <= active_d;
      col_q      <= col_d;
      idle_odd_q <= idle_odd_d;
      seen_q     <= seen_d;
    end
  end

  // R8
  contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (in_valid && !row_start));

  // R8
  gap_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && seen_q && !active_q) |-> !idle_odd_q);
endmodule

// File: rtl/lift_pe.sv
module lift_pe import lift_pkg::*; #(
  parameter int W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  lift_op_e            op_i,
  input  logic signed [W-1:0] opa_i,
  input  logic signed [W-1:0] opb_i,
  input  logic signed [W-1:0] base_i,
  output logic                res_vld_o,
  output lift_op_e            res_op_o,
  output logic signed [W-1:0] res_o
);
  localparam int SW = W + 1;

  logic                 s1_vld_q;
  lift_op_e             s1_op_q;
  logic signed [SW-1:0] sum_q, sum_d;
  logic signed [W-1:0]  base_q;
  logic signed [SW-1:0] term;
  logic                 cin;
  logic signed [SW:0]   acc;

  // stage 1: neighbour sum
  always_comb sum_d = SW'(opa_i) + SW'(opb_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s1_op_q  <= OP_PREDICT;
    end else begin
      s1_vld_q <= req_i;
      if (req_i) s1_op_q <= op_i;
    end
  end

  always_ff @(posedge clk) begin
    if (req_i) begin
      sum_q  <= sum_d;
      base_q <= base_i;
    end
  end

  // stage 2: scaled sum folded into one add with carry-in
  always_comb begin
    if (s1_op_q == OP_UPDATE) begin
      term = sum_q >>> 2;
      cin  = sum_q[1];
    end else begin
      term = ~(sum_q >>> 1);
      cin  = 1'b1;
    end
    acc   = (SW+1)'(base_q) + (SW+1)'(term) + (SW+1)'(cin);
    res_o = acc[W-1:0];
  end

  assign res_vld_o = s1_vld_q;
  assign res_op_o  = s1_op_q;

  // R6
  pe_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && s1_vld_q) |-> (op_i != s1_op_q));
endmodule

// File: rtl/lift_bank.sv
module lift_bank import lift_pkg::*; #(
  parameter int W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] sample_i,
  input  slot_meta_t          meta_i,
  input  logic                wr_pred_i,
  input  logic                wr_upd_i,
  input  logic signed [W-1:0] wr_val_i,
  output logic signed [W-1:0] data_o [1:BANK_DEPTH],
  output slot_meta_t          meta_o [1:BANK_DEPTH]
);
  logic signed [W-1:0] nxt [1:BANK_DEPTH];

  for (genvar k = 1; k <= BANK_DEPTH; k++) begin : g_slot
    if (k == 1) begin : g_head
      assign nxt[k] = sample_i;
    end else if (k == PRED_SLOT) begin : g_pred
      assign nxt[k] = wr_pred_i ? wr_val_i : data_o[k-1];
    end else if (k == UPD_SLOT) begin : g_upd
      assign nxt[k] = wr_upd_i ? wr_val_i : data_o[k-1];
    end else begin : g_pass
      assign nxt[k] = data_o[k-1];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 1; k <= BANK_DEPTH; k++) data_o[k] <= nxt[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k <= BANK_DEPTH; k++) meta_o[k] <= '0;
    end else begin
      meta_o[1] <= meta_i;
      for (int k = 2; k <= BANK_DEPTH; k++) meta_o[k] <= meta_o[k-1];
    end
  end

  // R6
  pred_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pred_i |-> (meta_o[PRED_SLOT-1].vld && meta_o[PRED_SLOT-1].odd));

  // R6
  upd_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_upd_i |-> (meta_o[UPD_SLOT-1].vld && !meta_o[UPD_SLOT-1].odd));
endmodule

// File: rtl/lift_row_top.sv
module lift_row_top import lift_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int ROW_LEN = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     row_start,
  input  logic [DATA_W-1:0]        in_sample,
  output logic                     out_valid,
  output logic                     out_high,
  output logic signed [DATA_W+1:0] out_coef
);
  localparam int CW = DATA_W + 2;

  logic                 rst_q;
  slot_meta_t           in_meta;
  logic signed [CW-1:0] sample;
  logic signed [CW-1:0] bank_d [1:BANK_DEPTH];
  slot_meta_t           bank_m [1:BANK_DEPTH];
  logic                 pred_req, upd_req, req;
  lift_op_e             op;
  logic signed [CW-1:0] opa, opb, base;
  logic                 res_vld;
  lift_op_e             res_op;
  logic signed [CW-1:0] res;
  logic                 wr_pred, wr_upd;
  logic                 hi_out, lo_out;

  lift_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q)
  );

  lift_ctrl #(.ROW_LEN(ROW_LEN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q),
    .in_valid  (in_valid),
    .row_start (row_start),
    .meta_o    (in_meta)
  );

  assign sample = CW'({1'b0, in_sample});

  // operand selection for the shared element
  always_comb begin
    pred_req = bank_m[1].vld & bank_m[1].odd;
    upd_req  = bank_m[HI_TAP].vld & bank_m[HI_TAP].odd;
    req      = pred_req | upd_req;
    if (upd_req) begin
      op   = OP_UPDATE;
      opa  = bank_d[HI_TAP];
      opb  = bank_m[HI_TAP+1].first ? '0 : bank_d[HI_TAP+2];
      base = bank_d[HI_TAP+1];
    end else begin
      op   = OP_PREDICT;
      opa  = bank_d[2];
      opb  = bank_m[1].last ? '0 : sample;
      base = bank_d[1];
    end
  end

  lift_pe #(.W(CW)) u_pe (
    .clk       (clk),
    .rst_n     (rst_q),
    .req_i     (req),
    .op_i      (op),
    .opa_i     (opa),
    .opb_i     (opb),
    .base_i    (base),
    .res_vld_o (res_vld),
    .res_op_o  (res_op),
    .res_o     (res)
  );

  assign wr_pred = res_vld && (res_op == OP_PREDICT);
  assign wr_upd  = res_vld && (res_op == OP_UPDATE);

  lift_bank #(.W(CW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_q),
    .sample_i  (sample),
    .meta_i    (in_meta),
    .wr_pred_i (wr_pred),
    .wr_upd_i  (wr_upd),
    .wr_val_i  (res),
    .data_o    (bank_d),
    .meta_o    (bank_m)
  );

  always_comb begin
    hi_out    = bank_m[HI_TAP].vld & bank_m[HI_TAP].odd;
    lo_out    = bank_m[LO_TAP].vld & !bank_m[LO_TAP].odd;
    out_valid = hi_out | lo_out;
    out_high  = hi_out;
    out_coef  = hi_out ? bank_d[HI_TAP] : bank_d[LO_TAP];
  end

  // R6
  no_collide_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !(pred_req && upd_req));

  // R5
  hi_alt_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && out_high) |=> !(out_valid && out_high));

  // R5
  lo_alt_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !out_high) |=> !(out_valid && !out_high));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_q |-> !out_valid);
endmodule

// File: tb/lift_row_top_test.sv
module lift_row_top_test;
  localparam int DW  = 8;
  localparam int N   = 16;
  localparam int CW  = DW + 2;
  localparam int WIN = 1024;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 in_valid;
  logic                 row_start;
  logic [DW-1:0]        in_sample;
  logic                 out_valid;
  logic                 out_high;
  logic signed [CW-1:0] out_coef;

  int unsigned edge_cnt = 0;
  int          checks   = 0;
  int          errors   = 0;
  bit          mon_on   = 1'b0;
  bit          exp_v [WIN];
  bit          exp_h [WIN];
  int          exp_c [WIN];
  int          row_x [N];
  int          ref_h [N/2];
  int          ref_l [N/2];
  int          mk;

  always #10 clk = ~clk;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  lift_row_top #(.DATA_W(DW), .ROW_LEN(N)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .row_start (row_start),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_high  (out_high),
    .out_coef  (out_coef)
  );

  // reference 5/3 lifting with zero extension (R2, R3)
  task automatic build_ref();
    for (int i = 0; i < N/2; i++) begin
      int nxt;
      nxt = (2*i + 2 < N) ? row_x[2*i+2] : 0;
      ref_h[i] = row_x[2*i+1] - ((row_x[2*i] + nxt) >>> 1);
    end
    for (int i = 0; i < N/2; i++) begin
      int prv;
      prv = (i > 0) ? ref_h[i-1] : 0;
      ref_l[i] = row_x[2*i] + ((prv + ref_h[i] + 2) >>> 2);
    end
  endtask

  // R4: H[i] after edge e+2i+4, L[i] after edge e+2i+7
  task automatic schedule(input int unsigned e);
    for (int i = 0; i < N/2; i++) begin
      exp_v[(e + 2*i + 4) % WIN] = 1'b1;
      exp_h[(e + 2*i + 4) % WIN] = 1'b1;
      exp_c[(e + 2*i + 4) % WIN] = ref_h[i];
      exp_v[(e + 2*i + 7) % WIN] = 1'b1;
      exp_h[(e + 2*i + 7) % WIN] = 1'b0;
      exp_c[(e + 2*i + 7) % WIN] = ref_l[i];
    end
  endtask

  task automatic send_row(input int kind);
    for (int j = 0; j < N; j++) begin
      case (kind)
        0:       row_x[j] = 0;
        1:       row_x[j] = 255;
        2:       row_x[j] = (j % 2) ? 255 : 0;
        3:       row_x[j] = (j % 2) ? 0 : 255;
        4:       row_x[j] = (j * 17) % 256;
        default: row_x[j] = int'($urandom_range(0, 255));
      endcase
    end
    build_ref();
    for (int j = 0; j < N; j++) begin
      @(negedge clk);
      if (j == 0) schedule(edge_cnt + 1);
      in_valid  = 1'b1;
      row_start = (j == 0);
      in_sample = DW'(row_x[j]);
    end
  endtask

  // R7: idle cycles, optionally carrying stray samples outside any row
  task automatic idle(input int cycles, input bit stray);
    for (int j = 0; j < cycles; j++) begin
      @(negedge clk);
      in_valid  = stray ? 1'($urandom_range(0, 1)) : 1'b0;
      row_start = 1'b0;
      in_sample = DW'($urandom_range(0, 255));
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      mk = int'(edge_cnt % WIN);
      checks++;
      if (out_valid !== exp_v[mk]) begin
        errors++;
        $display("FAIL R4,R7 edge %0d: out_valid actual %0b expected %0b",
                 edge_cnt, out_valid, exp_v[mk]);
      end else if (exp_v[mk]) begin
        checks++;
        if (out_high !== exp_h[mk]) begin
          errors++;
          $display("FAIL R5 edge %0d: out_high actual %0b expected %0b",
                   edge_cnt, out_high, exp_h[mk]);
        end
        checks++;
        if (int'(out_coef) != exp_c[mk]) begin
          errors++;
          if (exp_h[mk])
            $display("FAIL R2,R6,R8 edge %0d: high coef actual %0d expected %0d",
                     edge_cnt, out_coef, exp_c[mk]);
          else
            $display("FAIL R3,R6,R8 edge %0d: low coef actual %0d expected %0d",
                     edge_cnt, out_coef, exp_c[mk]);
        end
      end
      exp_v[mk] = 1'b0;
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL R4 watchdog: actual run still busy, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    row_start = 1'b0;
    in_sample = '0;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: out_valid actual %0b expected 0", out_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    idle(6, 1'b1);                    // R7: stray samples before any row

    send_row(0); idle(2, 1'b0);       // directed corners
    send_row(1); idle(0, 1'b0);
    send_row(2);                      // back-to-back rows (R8)
    send_row(3);
    send_row(4); idle(4, 1'b1);
    send_row(1);
    send_row(0); idle(2, 1'b1);

    for (int r = 0; r < 40; r++) begin
      send_row(9);
      idle(2 * int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    idle(N + 12, 1'b1);               // drain, with strays (R7)

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule